// File: doc/BRIEF.md
# Double-Buffered Side-Channel Packet Store

This block holds up to fifteen generic side-channel packets for a video transmitter. Every packet is a slot of nine 32-bit words: one header word, with header byte 0 in bits [7:0] up to byte 3 in bits [31:24], and then eight payload words. Software picks a slot by writing its number to a select register. This places an internal word index at the first word of that slot. Software then streams the words through one data register, and each write moves the index on by one.

Every slot has two copies. Software writes land in the pending copy. The transmitter reads only the active copy. A commit bit moves a slot's pending copy into its active copy in one cycle. Each slot has two such bits. The immediate bit acts on the next block-update pulse taken while the update lock is low. The frame bit acts on the next frame-start pulse. The transmit side reads one word at a time by slot and word offset. If software writes data while a transmit read is under way, a sticky conflict flag is set, and software clears that flag by writing a one to it.

Top module: `sidepkt_buffer`

## Requirements
- R1: After reset the index readback (offset 0) is 0, both commit registers (offsets 2 and 3) read 0, the status register (offset 4) reads 0, and every transmit read returns 0.
- R2: Writing a value n of at most 14 to the select register (offset 0) sets the index to n*9. A value above 14 is ignored and leaves the index unchanged.
- R3: A write to the data register (offset 1) stores the word in the pending copy at the current index, with slot = index/9 and word = index mod 9, and then raises the index by one.
- R4: Once the index has reached 135, which is one past the last word of slot 14, further data writes are discarded and the index stays at 135.
- R5: Transmit reads return active-copy contents only. Pending data is not visible on the transmit port until its slot has been committed.
- R6: Writing ones to the immediate commit register (offset 2, bit n = slot n) sets those bits, and writing zeros leaves bits unchanged. On a block-update pulse with the lock low, every slot whose bit is set has its pending copy copied to its active copy, and the bit reads 0 from the next cycle on.
- R7: A block-update pulse while the lock is high copies nothing and leaves the immediate commit bits set.
- R8: Writing ones to the frame commit register (offset 3, bit n = slot n) sets those bits. A frame-start pulse copies each flagged slot and clears its bit. Block-update pulses do not act on frame commit bits.
- R9: A data write in a cycle with tx_rd_en high sets status bit 0 (the conflict flag). The flag stays set until a status write with bit 0 equal to 1. A status write with bit 0 equal to 0 has no effect.
- R10: tx_busy is high in every cycle that tx_rd_en is high. tx_rdata shows the addressed active word from the cycle after tx_rd_en and holds its value while tx_rd_en is low. A slot above 14 or a word above 8 reads as 0.
- R11: A commit copies only flagged slots. The active copy of every other slot is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register readback offset |
| cfg_rdata | output | 32 | Register readback data (combinational) |
| blk_update | input | 1 | Block-update pulse for immediate commits |
| upd_lock | input | 1 | Update lock; while high, block-update pulses are ignored |
| frame_start | input | 1 | Frame-boundary pulse for frame commits |
| tx_rd_en | input | 1 | Transmit-side read request |
| tx_slot | input | 4 | Transmit read slot number |
| tx_word | input | 4 | Transmit read word offset within the slot |
| tx_busy | output | 1 | High while a transmit read is in progress |
| tx_rdata | output | 32 | Registered transmit read data from the active copy |

## Verification
A corrupted index shows up at once on the offset-0 readback. It also shows up later as words landing in the wrong slot or offset once that slot is committed and read on the transmit port. A commit bit that fails to clear, or that clears while the lock is high, is visible on the commit readback one cycle after the pulse. A wrong copy shows up on the transmit read of the first committed word. A lost or falsely cleared conflict flag appears on the status readback in the cycle after the offending write.

// File: rtl/sidepkt_pkg.sv
package sidepkt_pkg;

    // Register offsets on the configuration port
    typedef enum logic [2:0] {
        REG_SEL  = 3'd0,
        REG_DATA = 3'd1,
        REG_IMM  = 3'd2,
        REG_FRM  = 3'd3,
        REG_STAT = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic        we;
        logic [2:0]  addr;
    } cfg_cmd_t;

    function automatic logic hit(input cfg_cmd_t c, input reg_off_e r);
        return c.we && (c.addr == r);
    endfunction

endpackage

// File: rtl/sidepkt_index.sv
module sidepkt_index #(
    parameter int NUM_SLOTS  = 15,
    parameter int SLOT_WORDS = 9,
    parameter int DATA_W     = 32,
    parameter int SLOT_W     = 4,
    parameter int IDX_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [DATA_W-1:0] sel_data,
    input  logic              data_we,
    output logic [IDX_W-1:0]  idx_q,
    output logic              wr_accept
);
    localparam int TOTAL = NUM_SLOTS * SLOT_WORDS;
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(TOTAL);

    logic sel_ok;
    logic [IDX_W-1:0] sel_base;

    assign sel_ok    = sel_data < DATA_W'(NUM_SLOTS);
    assign sel_base  = IDX_W'(sel_data[SLOT_W-1:0]) * IDX_W'(SLOT_WORDS);
    assign wr_accept = data_we && (idx_q < END_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (sel_we && sel_ok) begin
            idx_q <= sel_base;
        end else if (wr_accept) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/sidepkt_slot.sv
module sidepkt_slot #(
    parameter int SLOT_WORDS = 9,
    parameter int DATA_W     = 32,
    parameter int WORD_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] pend_q [SLOT_WORDS];
    logic [DATA_W-1:0] act_q  [SLOT_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < SLOT_WORDS; w++) begin
                pend_q[w] <= '0;
                act_q[w]  <= '0;
            end
        end else begin
            for (int w = 0; w < SLOT_WORDS; w++) begin
                if (wr_en && wr_word == WORD_W'(w)) pend_q[w] <= wr_data;
                if (commit) act_q[w] <= pend_q[w];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < SLOT_WORDS; w++) begin
            if (rd_word == WORD_W'(w)) rd_data = act_q[w];
        end
    end
endmodule

// File: rtl/sidepkt_ctrl.sv
module sidepkt_ctrl #(
    parameter int NUM_SLOTS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] imm_set,
    input  logic [NUM_SLOTS-1:0] frm_set,
    input  logic                 blk_fire,
    input  logic                 frame_start,
    input  logic                 cflt_set,
    input  logic                 cflt_clr,
    output logic [NUM_SLOTS-1:0] imm_q,
    output logic [NUM_SLOTS-1:0] frm_q,
    output logic [NUM_SLOTS-1:0] commit,
    output logic                 conflict_q
);
    logic [NUM_SLOTS-1:0] imm_fire;
    logic [NUM_SLOTS-1:0] frm_fire;

    assign imm_fire = imm_q & {NUM_SLOTS{blk_fire}};
    assign frm_fire = frm_q & {NUM_SLOTS{frame_start}};
    assign commit   = imm_fire | frm_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            imm_q      <= '0;
            frm_q      <= '0;
            conflict_q <= 1'b0;
        end else begin
            // bits present at the event are consumed; new writes stay pending
            imm_q <= (imm_q & ~imm_fire) | imm_set;
            frm_q <= (frm_q & ~frm_fire) | frm_set;
            if (cflt_set)      conflict_q <= 1'b1;
            else if (cflt_clr) conflict_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sidepkt_buffer.sv
module sidepkt_buffer
    import sidepkt_pkg::*;
#(
    parameter int NUM_SLOTS  = 15,
    parameter int SLOT_WORDS = 9,
    parameter int DATA_W     = 32,
    parameter int SLOT_W     = $clog2(NUM_SLOTS),
    parameter int WORD_W     = $clog2(SLOT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [2:0]        cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              blk_update,
    input  logic              upd_lock,
    input  logic              frame_start,
    input  logic              tx_rd_en,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_busy,
    output logic [DATA_W-1:0] tx_rdata
);
    localparam int TOTAL = NUM_SLOTS * SLOT_WORDS;
    localparam int IDX_W = $clog2(TOTAL + 1);

    cfg_cmd_t cmd;
    assign cmd.we   = cfg_we;
    assign cmd.addr = cfg_addr;

    logic                 data_we;
    logic                 wr_accept;
    logic [IDX_W-1:0]     idx_q;
    logic [NUM_SLOTS-1:0] imm_q, frm_q, commit;
    logic                 conflict_q;
    logic [DATA_W-1:0]    slot_rd [NUM_SLOTS];
    logic [DATA_W-1:0]    tx_sel;

    assign data_we = hit(cmd, REG_DATA);
    assign tx_busy = tx_rd_en;

    sidepkt_index #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_WORDS(SLOT_WORDS),
        .DATA_W    (DATA_W),
        .SLOT_W    (SLOT_W),
        .IDX_W     (IDX_W)
    ) u_index (
        .clk      (clk),
        .rst      (rst),
        .sel_we   (hit(cmd, REG_SEL)),
        .sel_data (cfg_wdata),
        .data_we  (data_we),
        .idx_q    (idx_q),
        .wr_accept(wr_accept)
    );

    sidepkt_ctrl #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .imm_set    (hit(cmd, REG_IMM) ? cfg_wdata[NUM_SLOTS-1:0] : '0),
        .frm_set    (hit(cmd, REG_FRM) ? cfg_wdata[NUM_SLOTS-1:0] : '0),
        .blk_fire   (blk_update && !upd_lock),
        .frame_start(frame_start),
        .cflt_set   (data_we && tx_rd_en),
        .cflt_clr   (hit(cmd, REG_STAT) && cfg_wdata[0]),
        .imm_q      (imm_q),
        .frm_q      (frm_q),
        .commit     (commit),
        .conflict_q (conflict_q)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [IDX_W-1:0] BASE = IDX_W'(s * SLOT_WORDS);
        logic             in_slot;
        logic [IDX_W-1:0] offs;

        assign in_slot = (idx_q >= BASE) && (idx_q < BASE + IDX_W'(SLOT_WORDS));
        assign offs    = idx_q - BASE;

        sidepkt_slot #(
            .SLOT_WORDS(SLOT_WORDS),
            .DATA_W    (DATA_W),
            .WORD_W    (WORD_W)
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_accept && in_slot),
            .wr_word(offs[WORD_W-1:0]),
            .wr_data(cfg_wdata),
            .commit (commit[s]),
            .rd_word(tx_word),
            .rd_data(slot_rd[s])
        );
    end

    always_comb begin
        tx_sel = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (tx_slot == SLOT_W'(s)) tx_sel = slot_rd[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           tx_rdata <= '0;
        else if (tx_rd_en) tx_rdata <= tx_sel;
    end

    always_comb begin
        unique case (cfg_raddr)
            REG_SEL:  cfg_rdata = DATA_W'(idx_q);
            REG_IMM:  cfg_rdata = DATA_W'(imm_q);
            REG_FRM:  cfg_rdata = DATA_W'(frm_q);
            REG_STAT: cfg_rdata = DATA_W'(conflict_q);
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sidepkt_buffer_chk.sv
module sidepkt_buffer_chk
    import sidepkt_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 8,
    parameter int TOTAL     = 135
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [2:0]           cfg_addr,
    input logic [DATA_W-1:0]    cfg_wdata,
    input logic                 blk_update,
    input logic                 upd_lock,
    input logic                 frame_start,
    input logic                 tx_rd_en,
    input logic [DATA_W-1:0]    tx_rdata,
    input logic [IDX_W-1:0]     idx_q,
    input logic [NUM_SLOTS-1:0] imm_q,
    input logic [NUM_SLOTS-1:0] frm_q,
    input logic                 conflict_q
);
    logic wr_data_c, wr_imm_c, wr_frm_c, clr_c;
    assign wr_data_c = cfg_we && cfg_addr == REG_DATA;
    assign wr_imm_c  = cfg_we && cfg_addr == REG_IMM;
    assign wr_frm_c  = cfg_we && cfg_addr == REG_FRM;
    assign clr_c     = cfg_we && cfg_addr == REG_STAT && cfg_wdata[0];

    // R4
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(TOTAL));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data_c && idx_q < IDX_W'(TOTAL)) |=> idx_q == $past(idx_q) + 1'b1);

    // R6
    imm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_update && !upd_lock && !wr_imm_c) |=> ((imm_q & $past(imm_q)) == '0));

    // R7
    imm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_update && upd_lock && !wr_imm_c) |=> imm_q == $past(imm_q));

    // R8
    frm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !wr_frm_c) |=> ((frm_q & $past(frm_q)) == '0));

    // R9
    cflt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data_c && tx_rd_en) |=> conflict_q);

    // R9
    cflt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (conflict_q && !clr_c) |=> conflict_q);

    // R10
    txdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_rd_en |=> $stable(tx_rdata));
endmodule

bind sidepkt_buffer sidepkt_buffer_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .TOTAL    (TOTAL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .blk_update (blk_update),
    .upd_lock   (upd_lock),
    .frame_start(frame_start),
    .tx_rd_en   (tx_rd_en),
    .tx_rdata   (tx_rdata),
    .idx_q      (idx_q),
    .imm_q      (imm_q),
    .frm_q      (frm_q),
    .conflict_q (conflict_q)
);

// File: tb/sidepkt_buffer_bench.sv
`timescale 1ns/1ps
module sidepkt_buffer_bench;
    localparam logic [2:0] A_SEL = 3'd0, A_DATA = 3'd1, A_IMM = 3'd2,
                           A_FRM = 3'd3, A_STAT = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        blk_update = 1'b0;
    logic        upd_lock = 1'b0;
    logic        frame_start = 1'b0;
    logic        tx_rd_en = 1'b0;
    logic [3:0]  tx_slot = '0;
    logic [3:0]  tx_word = '0;
    logic        tx_busy;
    logic [31:0] tx_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sidepkt_buffer u_sidepkt_buffer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .blk_update(blk_update), .upd_lock(upd_lock), .frame_start(frame_start),
        .tx_rd_en(tx_rd_en), .tx_slot(tx_slot), .tx_word(tx_word),
        .tx_busy(tx_busy), .tx_rdata(tx_rdata)
    );

    function automatic logic [31:0] pat(input int slot, input int word, input int seed);
        return {8'(seed), 8'(slot), 8'(word), 8'h5A};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic tx_rd(input int slot, input int word, output logic [31:0] d);
        @(negedge clk);
        tx_rd_en = 1'b1; tx_slot = 4'(slot); tx_word = 4'(word);
        @(negedge clk);
        tx_rd_en = 1'b0;
        d = tx_rdata;
    endtask

    task automatic pulse(input bit blk, input bit lock, input bit frm);
        @(negedge clk);
        blk_update = blk; upd_lock = lock; frame_start = frm;
        @(negedge clk);
        blk_update = 1'b0; upd_lock = 1'b0; frame_start = 1'b0;
    endtask

    task automatic fill(input int slot, input int seed);
        cfg_wr(A_SEL, 32'(slot));
        for (int w = 0; w < 9; w++) cfg_wr(A_DATA, pat(slot, w, seed));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        cfg_rd(A_SEL, d);  chk("R1 index", d, 0);
        cfg_rd(A_IMM, d);  chk("R1 imm", d, 0);
        cfg_rd(A_FRM, d);  chk("R1 frm", d, 0);
        cfg_rd(A_STAT, d); chk("R1 stat", d, 0);
        tx_rd(3, 0, d);    chk("R1 active", d, 0);
    endtask

    task automatic t_select;
        logic [31:0] d;
        cfg_wr(A_SEL, 5);  cfg_rd(A_SEL, d); chk("R2 sel5", d, 45);
        cfg_wr(A_SEL, 15); cfg_rd(A_SEL, d); chk("R2 sel15 ignored", d, 45);
        cfg_wr(A_SEL, 14); cfg_rd(A_SEL, d); chk("R2 sel14", d, 126);
    endtask

    task automatic t_immediate;
        logic [31:0] d;
        fill(2, 1);
        cfg_rd(A_SEL, d);  chk("R3 index after fill", d, 27);
        tx_rd(2, 0, d);    chk("R5 pending hidden", d, 0);
        cfg_wr(A_IMM, 32'h4);
        cfg_rd(A_IMM, d);  chk("R6 imm pending", d, 32'h4);
        pulse(1, 1, 0);
        cfg_rd(A_IMM, d);  chk("R7 imm held", d, 32'h4);
        tx_rd(2, 0, d);    chk("R7 no copy", d, 0);
        pulse(1, 0, 0);
        cfg_rd(A_IMM, d);  chk("R6 imm cleared", d, 0);
        tx_rd(2, 0, d);    chk("R6 R3 word0", d, pat(2, 0, 1));
        tx_rd(2, 8, d);    chk("R3 word8", d, pat(2, 8, 1));
        tx_rd(2, 4, d);    chk("R3 word4", d, pat(2, 4, 1));
    endtask

    task automatic t_frame;
        logic [31:0] d;
        fill(7, 2);
        fill(1, 3);
        cfg_wr(A_FRM, 32'h80);
        pulse(1, 0, 0);
        cfg_rd(A_FRM, d);  chk("R8 blk ignores frm", d, 32'h80);
        tx_rd(7, 3, d);    chk("R8 no copy on blk", d, 0);
        pulse(0, 0, 1);
        cfg_rd(A_FRM, d);  chk("R8 frm cleared", d, 0);
        tx_rd(7, 3, d);    chk("R8 copied", d, pat(7, 3, 2));
        tx_rd(1, 3, d);    chk("R11 unflagged slot", d, 0);
        tx_rd(2, 0, d);    chk("R11 other slot kept", d, pat(2, 0, 1));
    endtask

    task automatic t_saturate;
        logic [31:0] d;
        fill(14, 4);
        cfg_rd(A_SEL, d);  chk("R4 index end", d, 135);
        cfg_wr(A_DATA, 32'hDEAD_BEEF);
        cfg_rd(A_SEL, d);  chk("R4 no wrap", d, 135);
        cfg_wr(A_IMM, 32'h4000);
        pulse(1, 0, 0);
        tx_rd(14, 8, d);   chk("R4 last word kept", d, pat(14, 8, 4));
        tx_rd(0, 0, d);    chk("R4 slot0 untouched", d, 0);
    endtask

    task automatic t_conflict_tx;
        logic [31:0] d;
        cfg_wr(A_SEL, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = A_DATA; cfg_wdata = 32'h1234_5678;
        tx_rd_en = 1'b1; tx_slot = 4'd2; tx_word = 4'd1;
        #0.5;
        chk("R10 busy", 32'(tx_busy), 1);
        @(negedge clk);
        cfg_we = 1'b0; tx_rd_en = 1'b0;
        chk("R10 read data", tx_rdata, pat(2, 1, 1));
        cfg_rd(A_STAT, d);  chk("R9 conflict set", d, 1);
        chk("R10 idle busy", 32'(tx_busy), 0);
        repeat (3) @(negedge clk);
        chk("R10 rdata holds", tx_rdata, pat(2, 1, 1));
        cfg_wr(A_STAT, 0);  cfg_rd(A_STAT, d); chk("R9 write0 no effect", d, 1);
        cfg_wr(A_STAT, 1);  cfg_rd(A_STAT, d); chk("R9 cleared", d, 0);
        tx_rd(15, 0, d);    chk("R10 bad slot", d, 0);
        tx_rd(2, 9, d);     chk("R10 bad word", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select();
        t_immediate();
        t_frame();
        t_saturate();
        t_conflict_tx();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule